// File: doc/BRIEF.md
# Register-Mapped Network Operand Port

This block connects a processor pipeline to a set of network channels, so that the channels behave like ordinary operand registers. A small, contiguous range of architectural register numbers is reserved. Each number in the range stands for one channel. When the decode stage names a reserved number as a source, the operand comes from that channel's receive queue and not from the register file. The word goes straight into the operand path, and the queue entry is consumed when the instruction issues. When writeback names a reserved number as the destination, the result goes into that channel's transmit queue and the register file is not written.

The block raises a decode stall while a named receive queue holds too few words. It raises a writeback stall while the named transmit queue is full. While either stall is active, no queue changes because of the stalled instruction. On the router side, each receive queue accepts words and each transmit queue offers words through valid/ready handshakes. Queue depth, channel count, the base register number and the word width are parameters.

Top module: `netreg_port`

## Requirements
- R1: After reset every receive queue is empty and ready (`in_ready` all ones) and every transmit queue is empty (`out_valid` all zeros).
- R2: An enabled source slot naming register BASE+c (default 24+c, c in 0..3) returns the oldest word of receive queue c. A source slot naming any other register returns its register-file input unchanged.
- R3: Each enabled source slot naming a reserved register removes exactly one word when the instruction issues (`issue_valid` high and `decode_stall` low). Words come out in arrival order.
- R4: When both source slots name the same reserved register, slot A receives the oldest word, slot B receives the next word, and both words are removed on issue.
- R5: `decode_stall` is high exactly when `issue_valid` is high and some channel holds fewer words than the enabled slots naming it. While stalled, no word is removed.
- R6: A writeback (`wb_valid`) to a reserved register that is not stalled appends `wb_data` to that channel's transmit queue and keeps `rf_we` low. A writeback to any other register raises `rf_we` and touches no transmit queue.
- R7: `wb_stall` is high while a writeback names a channel whose transmit queue holds DEPTH (default 4) words. During the stall nothing is appended and `rf_we` stays low. The write completes once a slot frees.
- R8: A receive queue holding DEPTH words drives its `in_ready` low, and a word offered while it is full is discarded.
- R9: A transmit word leaves the queue only on a cycle with `out_valid` and `out_ready` both high. While it waits, `out_data` holds it. Words leave in the order they were written.
- R10: A source slot whose enable is low returns its register-file input, never stalls and removes nothing, even if it names a reserved register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Decode stage presents an instruction |
| src_a_en | input | 1 | Source slot A is used |
| src_a_reg | input | 5 | Source slot A register number |
| src_a_rf | input | 32 | Register-file value for slot A |
| src_b_en | input | 1 | Source slot B is used |
| src_b_reg | input | 5 | Source slot B register number |
| src_b_rf | input | 32 | Register-file value for slot B |
| src_a_val | output | 32 | Operand delivered for slot A |
| src_b_val | output | 32 | Operand delivered for slot B |
| decode_stall | output | 1 | Hold decode: a named receive queue is short |
| wb_valid | input | 1 | Writeback stage presents a result |
| wb_rd | input | 5 | Destination register number |
| wb_data | input | 32 | Result value |
| wb_stall | output | 1 | Hold writeback: named transmit queue is full |
| rf_we | output | 1 | Register-file write enable for this result |
| in_valid | input | 4 | Router offers a word, one bit per channel |
| in_ready | output | 4 | Receive queue has space, per channel |
| in_data | input | 4x32 | Router words, per channel |
| out_valid | output | 4 | Transmit queue holds a word, per channel |
| out_ready | input | 4 | Router accepts a word, per channel |
| out_data | output | 4x32 | Oldest transmit word, per channel |

## Verification
Two situations are the hardest to reach from the ports. The first is a writeback that stalls against a full transmit queue and then completes in the same cycle the router frees a slot. The bench keeps `out_ready` low until four results are queued and holds a fifth writeback. It then opens `out_ready` and checks that the stall drops one cycle later and that all five words drain in order. The second is a double read of one register when the queue holds exactly one word. The bench loads a single word, keeps the double-read instruction stalled, and feeds the second word while the instruction waits. It then checks that both operands arrive in arrival order and that nothing was removed during the stall.

// File: rtl/netreg_pkg.sv
package netreg_pkg;

  // Number of words a single instruction removes from one receive queue
  typedef enum logic [1:0] {
    POP_NONE = 2'd0,
    POP_ONE  = 2'd1,
    POP_TWO  = 2'd2
  } pop_e;

endpackage

// File: rtl/netreg_decode.sv
module netreg_decode #(
  parameter int REG_W = 5,
  parameter int BASE  = 24,
  parameter int NCH   = 4,
  parameter int CHW   = 2
) (
  input  logic             en_i,
  input  logic [REG_W-1:0] reg_i,
  output logic             hit_o,
  output logic [CHW-1:0]   ch_o
);

  int offs;

  always_comb begin
    offs  = int'(reg_i) - BASE;
    hit_o = en_i && (offs >= 0) && (offs < NCH);
    ch_o  = CHW'(offs);
  end

endmodule

// File: rtl/netreg_in_fifo.sv
module netreg_in_fifo
  import netreg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [DATA_W-1:0] push_data,
  input  pop_e              pop_i,
  output logic [CW-1:0]     level_o,
  output logic [DATA_W-1:0] head_o,
  output logic [DATA_W-1:0] second_o
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     rd_ptr, rd_ptr_d;
  logic [AW-1:0]     wr_ptr, wr_ptr_d;
  logic [CW-1:0]     count, count_d;
  logic              push_fire;

  // next state
  always_comb begin
    push_ready = (count != CW'(DEPTH));
    push_fire  = push_valid && push_ready;
    count_d    = count + CW'(push_fire) - CW'(pop_i);
    rd_ptr_d   = rd_ptr + AW'(pop_i);
    wr_ptr_d   = wr_ptr + AW'(push_fire);
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      rd_ptr <= rd_ptr_d;
      wr_ptr <= wr_ptr_d;
      count  <= count_d;
    end
  end

  // storage, written only under its enable
  always_ff @(posedge clk) begin
    if (push_fire) begin
      mem[wr_ptr] <= push_data;
    end
  end

  assign level_o  = count;
  assign head_o   = mem[rd_ptr];
  assign second_o = mem[rd_ptr + AW'(1)];

endmodule

// File: rtl/netreg_out_fifo.sv
module netreg_out_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_en,
  input  logic [DATA_W-1:0] push_data,
  output logic              full_o,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     rd_ptr, rd_ptr_d;
  logic [AW-1:0]     wr_ptr, wr_ptr_d;
  logic [CW-1:0]     count, count_d;
  logic              pop_fire, push_fire;

  always_comb begin
    full_o    = (count == CW'(DEPTH));
    out_valid = (count != '0);
    pop_fire  = out_valid && out_ready;
    push_fire = push_en && !full_o;
    count_d   = count + CW'(push_fire) - CW'(pop_fire);
    rd_ptr_d  = rd_ptr + AW'(pop_fire);
    wr_ptr_d  = wr_ptr + AW'(push_fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      rd_ptr <= rd_ptr_d;
      wr_ptr <= wr_ptr_d;
      count  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_fire) begin
      mem[wr_ptr] <= push_data;
    end
  end

  assign out_data = mem[rd_ptr];

endmodule

// File: rtl/netreg_port.sv
module netreg_port
  import netreg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NCH    = 4,
  parameter int DEPTH  = 4,
  parameter int REG_W  = 5,
  parameter int BASE   = 24,
  localparam int CHW   = $clog2(NCH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       issue_valid,
  input  logic                       src_a_en,
  input  logic [REG_W-1:0]           src_a_reg,
  input  logic [DATA_W-1:0]          src_a_rf,
  input  logic                       src_b_en,
  input  logic [REG_W-1:0]           src_b_reg,
  input  logic [DATA_W-1:0]          src_b_rf,
  output logic [DATA_W-1:0]          src_a_val,
  output logic [DATA_W-1:0]          src_b_val,
  output logic                       decode_stall,
  input  logic                       wb_valid,
  input  logic [REG_W-1:0]           wb_rd,
  input  logic [DATA_W-1:0]          wb_data,
  output logic                       wb_stall,
  output logic                       rf_we,
  input  logic [NCH-1:0]             in_valid,
  output logic [NCH-1:0]             in_ready,
  input  logic [NCH-1:0][DATA_W-1:0] in_data,
  output logic [NCH-1:0]             out_valid,
  input  logic [NCH-1:0]             out_ready,
  output logic [NCH-1:0][DATA_W-1:0] out_data
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync[1];

  // register number decode for both sources and the destination
  logic           a_hit, b_hit, d_hit;
  logic [CHW-1:0] a_ch, b_ch, d_ch;

  netreg_decode #(.REG_W(REG_W), .BASE(BASE), .NCH(NCH), .CHW(CHW)) u_dec_a (
    .en_i(src_a_en), .reg_i(src_a_reg), .hit_o(a_hit), .ch_o(a_ch));
  netreg_decode #(.REG_W(REG_W), .BASE(BASE), .NCH(NCH), .CHW(CHW)) u_dec_b (
    .en_i(src_b_en), .reg_i(src_b_reg), .hit_o(b_hit), .ch_o(b_ch));
  netreg_decode #(.REG_W(REG_W), .BASE(BASE), .NCH(NCH), .CHW(CHW)) u_dec_d (
    .en_i(wb_valid), .reg_i(wb_rd), .hit_o(d_hit), .ch_o(d_ch));

  // per-channel queue state
  logic [NCH-1:0][CW-1:0]     in_lvl;
  logic [NCH-1:0][DATA_W-1:0] rx_head, rx_second;
  logic [NCH-1:0][1:0]        need;
  logic [NCH-1:0]             short_ch;
  pop_e                       pop_sel [NCH];
  logic [NCH-1:0]             tx_full, tx_push;
  logic                       issue_go;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      need[c] = {1'b0, a_hit && (a_ch == CHW'(c))}
              + {1'b0, b_hit && (b_ch == CHW'(c))};
      short_ch[c] = (in_lvl[c] < CW'(need[c]));
    end
    decode_stall = issue_valid && (|short_ch);
    issue_go     = issue_valid && !decode_stall;
    for (int c = 0; c < NCH; c++) begin
      pop_sel[c] = issue_go ? pop_e'(need[c]) : POP_NONE;
    end
  end

  // operand selection feeding the bypass network
  always_comb begin
    src_a_val = a_hit ? rx_head[a_ch] : src_a_rf;
    if (!b_hit) begin
      src_b_val = src_b_rf;
    end else if (a_hit && (a_ch == b_ch)) begin
      src_b_val = rx_second[b_ch];
    end else begin
      src_b_val = rx_head[b_ch];
    end
  end

  // writeback steering
  always_comb begin
    wb_stall = d_hit && tx_full[d_ch];
    rf_we    = wb_valid && !d_hit;
    for (int c = 0; c < NCH; c++) begin
      tx_push[c] = d_hit && (d_ch == CHW'(c));
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    netreg_in_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .push_valid (in_valid[g]),
      .push_ready (in_ready[g]),
      .push_data  (in_data[g]),
      .pop_i      (pop_sel[g]),
      .level_o    (in_lvl[g]),
      .head_o     (rx_head[g]),
      .second_o   (rx_second[g])
    );

    netreg_out_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .push_en   (tx_push[g]),
      .push_data (wb_data),
      .full_o    (tx_full[g]),
      .out_valid (out_valid[g]),
      .out_ready (out_ready[g]),
      .out_data  (out_data[g])
    );
  end

endmodule

// File: rtl/netreg_port_chk.sv
module netreg_port_chk #(
  parameter int DATA_W = 32,
  parameter int NCH    = 4,
  parameter int DEPTH  = 4,
  parameter int REG_W  = 5,
  parameter int BASE   = 24,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       issue_valid,
  input logic                       decode_stall,
  input logic                       wb_valid,
  input logic [REG_W-1:0]           wb_rd,
  input logic                       wb_stall,
  input logic                       rf_we,
  input logic [NCH-1:0]             in_valid,
  input logic [NCH-1:0]             out_valid,
  input logic [NCH-1:0]             out_ready,
  input logic [NCH-1:0][DATA_W-1:0] out_data,
  input logic [NCH-1:0][CW-1:0]     in_lvl
);

  logic rd_reserved;
  assign rd_reserved = (int'(wb_rd) >= BASE) && (int'(wb_rd) < BASE + NCH);

  // R7
  wb_stall_blocks_rf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stall |-> !rf_we);

  // R6
  rf_write_plain_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (wb_valid && !rd_reserved));

  // R5
  stall_needs_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decode_stall |-> issue_valid);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R8
    rx_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_lvl[g] <= CW'(DEPTH));

    // R5
    stall_keeps_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (decode_stall && !in_valid[g]) |=> (in_lvl[g] == $past(in_lvl[g])));

    // R9
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[g] && !out_ready[g]) |=> (out_valid[g] && $stable(out_data[g])));
  end

endmodule

bind netreg_port netreg_port_chk #(
  .DATA_W(DATA_W), .NCH(NCH), .DEPTH(DEPTH), .REG_W(REG_W), .BASE(BASE)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .issue_valid  (issue_valid),
  .decode_stall (decode_stall),
  .wb_valid     (wb_valid),
  .wb_rd        (wb_rd),
  .wb_stall     (wb_stall),
  .rf_we        (rf_we),
  .in_valid     (in_valid),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .in_lvl       (in_lvl)
);

// File: tb/tb_netreg_port.sv
module tb_netreg_port;

  logic             clk;
  logic             rst_n;
  logic             issue_valid;
  logic             src_a_en, src_b_en;
  logic [4:0]       src_a_reg, src_b_reg;
  logic [31:0]      src_a_rf, src_b_rf;
  logic [31:0]      src_a_val, src_b_val;
  logic             decode_stall;
  logic             wb_valid;
  logic [4:0]       wb_rd;
  logic [31:0]      wb_data;
  logic             wb_stall;
  logic             rf_we;
  logic [3:0]       in_valid, in_ready;
  logic [3:0][31:0] in_data;
  logic [3:0]       out_valid, out_ready;
  logic [3:0][31:0] out_data;

  int checks = 0;
  int fails  = 0;

  netreg_port dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
    .src_a_en(src_a_en), .src_a_reg(src_a_reg), .src_a_rf(src_a_rf),
    .src_b_en(src_b_en), .src_b_reg(src_b_reg), .src_b_rf(src_b_rf),
    .src_a_val(src_a_val), .src_b_val(src_b_val), .decode_stall(decode_stall),
    .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_data(wb_data), .wb_stall(wb_stall),
    .rf_we(rf_we), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic push_in(input int c, input logic [31:0] w);
    in_valid[c] = 1'b1;
    in_data[c]  = w;
    step();
    in_valid[c] = 1'b0;
  endtask

  task automatic issue(input logic aen, input logic [4:0] ar, input logic [31:0] arf,
                       input logic ben, input logic [4:0] br, input logic [31:0] brf);
    issue_valid = 1'b1;
    src_a_en = aen; src_a_reg = ar; src_a_rf = arf;
    src_b_en = ben; src_b_reg = br; src_b_rf = brf;
  endtask

  task automatic idle();
    issue_valid = 1'b0;
    src_a_en = 1'b0;
    src_b_en = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "in_ready", 32'(in_ready), 32'hF);
    chk("R1", "out_valid", 32'(out_valid), 32'h0);
    chk("R1", "decode_stall", 32'(decode_stall), 32'h0);
  endtask

  task automatic t_rf_path();
    issue(1'b1, 5'd5, 32'h5555, 1'b1, 5'd7, 32'h7777);
    @(negedge clk);
    chk("R2", "plain src_a", src_a_val, 32'h5555);
    chk("R2", "plain src_b", src_b_val, 32'h7777);
    chk("R2", "plain stall", 32'(decode_stall), 32'h0);
    step();
    idle();
  endtask

  task automatic t_single();
    push_in(1, 32'hA1);
    push_in(1, 32'hA2);
    issue(1'b1, 5'd25, 32'h0, 1'b1, 5'd3, 32'h33);
    @(negedge clk);
    chk("R2", "ch1 head", src_a_val, 32'hA1);
    chk("R2", "rf beside net", src_b_val, 32'h33);
    step();
    @(negedge clk);
    chk("R3", "ch1 second pop", src_a_val, 32'hA2);
    step();
    @(negedge clk);
    chk("R5", "empty stall", 32'(decode_stall), 32'h1);
    step();
    @(negedge clk);
    chk("R5", "stall held", 32'(decode_stall), 32'h1);
    in_valid[1] = 1'b1;
    in_data[1]  = 32'hA3;
    step();
    in_valid[1] = 1'b0;
    @(negedge clk);
    chk("R5", "released stall", 32'(decode_stall), 32'h0);
    chk("R5", "word after stall", src_a_val, 32'hA3);
    step();
    idle();
  endtask

  task automatic t_double();
    push_in(2, 32'hB1);
    push_in(2, 32'hB2);
    issue(1'b1, 5'd26, 32'h0, 1'b1, 5'd26, 32'h0);
    @(negedge clk);
    chk("R4", "dup slot a", src_a_val, 32'hB1);
    chk("R4", "dup slot b", src_b_val, 32'hB2);
    step();
    idle();
    push_in(2, 32'hB3);
    issue(1'b1, 5'd26, 32'h0, 1'b1, 5'd26, 32'h0);
    @(negedge clk);
    chk("R5", "dup one word stall", 32'(decode_stall), 32'h1);
    in_valid[2] = 1'b1;
    in_data[2]  = 32'hB4;
    step();
    in_valid[2] = 1'b0;
    @(negedge clk);
    chk("R4", "dup late a", src_a_val, 32'hB3);
    chk("R4", "dup late b", src_b_val, 32'hB4);
    chk("R4", "dup late stall", 32'(decode_stall), 32'h0);
    step();
    idle();
    push_in(0, 32'hC0);
    push_in(3, 32'hD3);
    issue(1'b1, 5'd27, 32'h0, 1'b1, 5'd24, 32'h0);
    @(negedge clk);
    chk("R2", "cross a ch3", src_a_val, 32'hD3);
    chk("R2", "cross b ch0", src_b_val, 32'hC0);
    step();
    idle();
  endtask

  task automatic t_disabled();
    push_in(0, 32'hE0);
    issue(1'b0, 5'd24, 32'hAAAA, 1'b0, 5'd27, 32'hBBBB);
    @(negedge clk);
    chk("R10", "disabled stall", 32'(decode_stall), 32'h0);
    chk("R10", "disabled a", src_a_val, 32'hAAAA);
    chk("R10", "disabled b", src_b_val, 32'hBBBB);
    step();
    issue(1'b1, 5'd24, 32'h0, 1'b0, 5'd0, 32'h0);
    @(negedge clk);
    chk("R10", "word kept", src_a_val, 32'hE0);
    step();
    idle();
  endtask

  task automatic t_in_full();
    for (int i = 0; i < 4; i++) push_in(3, 32'hF0 + 32'(i));
    @(negedge clk);
    chk("R8", "full ready low", 32'(in_ready[3]), 32'h0);
    in_valid[3] = 1'b1;
    in_data[3]  = 32'hFF;
    step();
    in_valid[3] = 1'b0;
    for (int i = 0; i < 4; i++) begin
      issue(1'b1, 5'd27, 32'h0, 1'b0, 5'd0, 32'h0);
      @(negedge clk);
      chk("R3", "ch3 order", src_a_val, 32'hF0 + 32'(i));
      step();
    end
    @(negedge clk);
    chk("R8", "overflow dropped", 32'(decode_stall), 32'h1);
    step();
    idle();
  endtask

  task automatic t_wb();
    wb_valid = 1'b1; wb_rd = 5'd25; wb_data = 32'h11;
    @(negedge clk);
    chk("R6", "net dest rf_we", 32'(rf_we), 32'h0);
    chk("R6", "net dest stall", 32'(wb_stall), 32'h0);
    step();
    wb_rd = 5'd9; wb_data = 32'h99;
    @(negedge clk);
    chk("R6", "tx1 valid", 32'(out_valid), 32'h2);
    chk("R6", "tx1 data", out_data[1], 32'h11);
    chk("R6", "plain dest rf_we", 32'(rf_we), 32'h1);
    step();
    wb_valid = 1'b0;
    @(negedge clk);
    chk("R6", "plain no enqueue", 32'(out_valid), 32'h2);
    out_ready[1] = 1'b1;
    step();
    out_ready[1] = 1'b0;
    @(negedge clk);
    chk("R9", "tx1 drained", 32'(out_valid[1]), 32'h0);
  endtask

  task automatic t_out_full();
    for (int i = 0; i < 4; i++) begin
      wb_valid = 1'b1; wb_rd = 5'd26; wb_data = 32'hC00 + 32'(i);
      step();
    end
    wb_data = 32'hC04;
    @(negedge clk);
    chk("R7", "full stall", 32'(wb_stall), 32'h1);
    chk("R7", "full rf_we", 32'(rf_we), 32'h0);
    step();
    @(negedge clk);
    chk("R7", "stall held", 32'(wb_stall), 32'h1);
    chk("R9", "head waits", out_data[2], 32'hC00);
    out_ready[2] = 1'b1;
    step();
    @(negedge clk);
    chk("R7", "stall released", 32'(wb_stall), 32'h0);
    chk("R9", "drain 1", out_data[2], 32'hC01);
    step();
    wb_valid = 1'b0;
    for (int i = 2; i < 5; i++) begin
      @(negedge clk);
      chk("R9", "drain order", out_data[2], 32'hC00 + 32'(i));
      step();
    end
    @(negedge clk);
    chk("R9", "drained empty", 32'(out_valid[2]), 32'h0);
    out_ready[2] = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog all actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    issue_valid = 1'b0; src_a_en = 1'b0; src_b_en = 1'b0;
    src_a_reg = '0; src_b_reg = '0; src_a_rf = '0; src_b_rf = '0;
    wb_valid = 1'b0; wb_rd = '0; wb_data = '0;
    in_valid = '0; in_data = '0; out_ready = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    t_reset();
    t_rf_path();
    t_single();
    t_double();
    t_disabled();
    t_in_full();
    t_wb();
    t_out_full();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule